// File: doc/BRIEF.md
# Time-Multiplexed Eight-Port Nibble Interface

This block joins eight 10 Mbit/s MAC channels to one nibble-wide link toward an external multiplexing PHY. The link runs on a 20 MHz clock supplied by the PHY. Each clock cycle is a slot that belongs to one port. A frame marker from the PHY identifies the slot of port 0, and the next seven cycles belong to ports 1 to 7 in turn. Each port therefore moves one nibble per eight-cycle rotation, which is 2.5 MHz × 4 bits = 10 Mbit/s.

On the MAC side, every port has its own parallel transmit nibble and enable, and its own registered receive nibble, data-valid, carrier, collision and link outputs. The PHY qualifies the collision and data-valid flags per slot. Collision means a collision was seen during any of the slot's four bit times. Data-valid means all four bits of the nibble are good. The block passes both flags through unchanged. It also drives a slot-multiplexed renegotiation line. When a port requests renegotiation, the line carries a high, low, high pattern in that port's own slots, which asks the PHY to renegotiate duplex and flow control for that port.

Top module: `tdm_mac_mux`

## Requirements
- R1: The cycle with `phy_sync_i` high is the slot of port 0. Each following cycle is the slot of the next port, and port 7 is followed by port 0 again, whether or not the marker repeats.
- R2: In every slot, `phy_txd_o` and `phy_txen_o` carry the transmit nibble and enable of that slot's port. Before the first marker has been seen, both are 0.
- R3: At the end of port p's slot, the shared receive nibble, data-valid, carrier, collision and link inputs are stored as port p's outputs. The new values appear in the next cycle.
- R4: A port's receive outputs hold their value until the end of that port's next slot. In any cycle, at most one port's receive outputs change.
- R5: A marker that arrives in any slot forces that cycle to be port 0's slot, and counting continues from there.
- R6: `sync_err_o` is high for exactly one cycle, the cycle after a marker arrives when the marker was expected at a slot other than 0, after a marker has already been seen. Otherwise it stays low.
- R7: A request on `reneg_req_i[p]` while port p is idle makes `phy_reneg_o` read 1, 0, 1 in port p's next three slots. In every other slot, and before the first marker, `phy_reneg_o` reads 0.
- R8: A request for a port whose 1-0-1 pattern is still running is ignored and does not restart the pattern.
- R9: While reset is active, and until the first marker, all receive outputs and `sync_err_o` are 0, and the inputs of the shared link are not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied link clock (20 MHz) |
| rst_n | input | 1 | asynchronous active-low reset |
| tx_nib_i | input | NPORTS*NW | transmit nibble per port, port p at bits [p*NW +: NW] |
| tx_en_i | input | NPORTS | transmit enable per port |
| rx_nib_o | output | NPORTS*NW | held receive nibble per port |
| rx_dv_o | output | NPORTS | held data-valid per port |
| rx_crs_o | output | NPORTS | held carrier sense per port |
| rx_col_o | output | NPORTS | held collision per port |
| rx_link_o | output | NPORTS | held link status per port |
| reneg_req_i | input | NPORTS | renegotiation request per port |
| phy_sync_i | input | 1 | slot marker for port 0 |
| phy_rxd_i | input | NW | shared receive nibble |
| phy_rxdv_i | input | 1 | shared data-valid flag |
| phy_crs_i | input | 1 | shared carrier sense |
| phy_col_i | input | 1 | shared collision flag |
| phy_link_i | input | 1 | shared link status |
| phy_txd_o | output | NW | shared transmit nibble |
| phy_txen_o | output | 1 | shared transmit enable |
| phy_reneg_o | output | 1 | slot-multiplexed renegotiation line |
| sync_err_o | output | 1 | one-cycle misplaced-marker pulse |

## Verification
The transmit nibble, transmit enable and renegotiation line depend combinationally on the current slot, so they are due in the same cycle as the inputs that select them. The bench drives inputs on the falling edge and compares these outputs just after that edge. Receive captures and the marker-error pulse are due one clock after the slot that caused them. The reference model applies its update only after the compare, so every registered output is checked against the state left by the previous rising edge. The marker schedule covers early, late, missing and back-to-back markers, and renegotiation requests are repeated while a pattern is still running.

// File: rtl/tdm_mux_pkg.sv
package tdm_mux_pkg;
  typedef enum logic [1:0] {
    RN_IDLE  = 2'd0,
    RN_HIGH1 = 2'd1,
    RN_LOW   = 2'd2,
    RN_HIGH2 = 2'd3
  } reneg_st_e;
endpackage

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker #(
  parameter int NPORTS = 8,
  localparam int SW = $clog2(NPORTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic [SW-1:0] slot_o,
  output logic          active_o,
  output logic          sync_err_o
);
  localparam logic [SW-1:0] LAST = SW'(NPORTS - 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          lock_q, lock_d;
  logic          err_q, err_d;

  always_comb begin
    slot_o   = sync_i ? '0 : cnt_q;
    active_o = sync_i | lock_q;
    cnt_d    = cnt_q;
    if (active_o) cnt_d = (slot_o == LAST) ? '0 : slot_o + 1'b1;
    lock_d   = lock_q | sync_i;
    err_d    = sync_i & lock_q & (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
      err_q  <= err_d;
    end
  end

  assign sync_err_o = err_q;
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
  parameter int NPORTS = 8,
  parameter int NW     = 4,
  localparam int SW = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [SW-1:0]     slot_i,
  input  logic [NW-1:0]     rxd_i,
  input  logic              dv_i,
  input  logic              crs_i,
  input  logic              col_i,
  input  logic              link_i,
  output logic [NPORTS*NW-1:0] nib_o,
  output logic [NPORTS-1:0] dv_o,
  output logic [NPORTS-1:0] crs_o,
  output logic [NPORTS-1:0] col_o,
  output logic [NPORTS-1:0] link_o
);
  localparam int FW = NW + 4;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic          en;
    logic [FW-1:0] fld_q, fld_d;

    always_comb begin
      en    = active_i && (slot_i == SW'(p));
      fld_d = en ? {rxd_i, dv_i, crs_i, col_i, link_i} : fld_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fld_q <= '0;
      else        fld_q <= fld_d;
    end

    assign nib_o[p*NW +: NW] = fld_q[FW-1 -: NW];
    assign dv_o[p]   = fld_q[3];
    assign crs_o[p]  = fld_q[2];
    assign col_o[p]  = fld_q[1];
    assign link_o[p] = fld_q[0];
  end
endmodule

// File: rtl/tdm_reneg_seq.sv
module tdm_reneg_seq
  import tdm_mux_pkg::*;
#(
  parameter int NPORTS = 8,
  localparam int SW = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [SW-1:0]     slot_i,
  input  logic [NPORTS-1:0] req_i,
  output logic              reneg_o
);
  logic [NPORTS-1:0] bit_hi;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    reneg_st_e st_q, st_d;
    logic      en;

    always_comb begin
      en   = active_i && (slot_i == SW'(p));
      st_d = st_q;
      if (st_q == RN_IDLE) begin
        if (req_i[p]) st_d = RN_HIGH1;
      end else if (en) begin
        case (st_q)
          RN_HIGH1: st_d = RN_LOW;
          RN_LOW:   st_d = RN_HIGH2;
          default:  st_d = RN_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= RN_IDLE;
      else        st_q <= st_d;
    end

    assign bit_hi[p] = (st_q == RN_HIGH1) || (st_q == RN_HIGH2);
  end

  assign reneg_o = active_i & bit_hi[slot_i];
endmodule

// File: rtl/tdm_mac_mux.sv
module tdm_mac_mux #(
  parameter int NPORTS = 8,
  parameter int NW     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS*NW-1:0] tx_nib_i,
  input  logic [NPORTS-1:0]    tx_en_i,
  output logic [NPORTS*NW-1:0] rx_nib_o,
  output logic [NPORTS-1:0]    rx_dv_o,
  output logic [NPORTS-1:0]    rx_crs_o,
  output logic [NPORTS-1:0]    rx_col_o,
  output logic [NPORTS-1:0]    rx_link_o,
  input  logic [NPORTS-1:0]    reneg_req_i,
  input  logic                 phy_sync_i,
  input  logic [NW-1:0]        phy_rxd_i,
  input  logic                 phy_rxdv_i,
  input  logic                 phy_crs_i,
  input  logic                 phy_col_i,
  input  logic                 phy_link_i,
  output logic [NW-1:0]        phy_txd_o,
  output logic                 phy_txen_o,
  output logic                 phy_reneg_o,
  output logic                 sync_err_o
);
  localparam int SW = $clog2(NPORTS);

  logic [SW-1:0] slot;
  logic          active;

  tdm_slot_tracker #(.NPORTS(NPORTS)) u_trk (
    .clk(clk), .rst_n(rst_n), .sync_i(phy_sync_i),
    .slot_o(slot), .active_o(active), .sync_err_o(sync_err_o)
  );

  tdm_rx_capture #(.NPORTS(NPORTS), .NW(NW)) u_rx (
    .clk(clk), .rst_n(rst_n), .active_i(active), .slot_i(slot),
    .rxd_i(phy_rxd_i), .dv_i(phy_rxdv_i), .crs_i(phy_crs_i),
    .col_i(phy_col_i), .link_i(phy_link_i),
    .nib_o(rx_nib_o), .dv_o(rx_dv_o), .crs_o(rx_crs_o),
    .col_o(rx_col_o), .link_o(rx_link_o)
  );

  tdm_reneg_seq #(.NPORTS(NPORTS)) u_rn (
    .clk(clk), .rst_n(rst_n), .active_i(active), .slot_i(slot),
    .req_i(reneg_req_i), .reneg_o(phy_reneg_o)
  );

  always_comb begin
    phy_txd_o  = active ? tx_nib_i[slot*NW +: NW] : '0;
    phy_txen_o = active & tx_en_i[slot];
  end
endmodule

// File: rtl/tdm_mux_checker.sv
module tdm_mux_checker #(
  parameter int NPORTS = 8,
  parameter int NW     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NPORTS*NW-1:0] tx_nib_i,
  input logic [NPORTS-1:0]    tx_en_i,
  input logic [NPORTS*NW-1:0] rx_nib_o,
  input logic [NPORTS-1:0]    rx_dv_o,
  input logic [NPORTS-1:0]    rx_crs_o,
  input logic [NPORTS-1:0]    rx_col_o,
  input logic [NPORTS-1:0]    rx_link_o,
  input logic                 phy_sync_i,
  input logic [NW-1:0]        phy_txd_o,
  input logic                 phy_txen_o,
  input logic                 phy_reneg_o,
  input logic                 sync_err_o
);
  logic seen_q;
  logic sync_prev_q;
  logic [NPORTS*NW-1:0] nib_prev_q;
  logic [NPORTS-1:0] dv_prev_q, crs_prev_q, col_prev_q, link_prev_q;
  logic [NPORTS-1:0] chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      sync_prev_q <= 1'b0;
      nib_prev_q  <= '0;
      dv_prev_q   <= '0;
      crs_prev_q  <= '0;
      col_prev_q  <= '0;
      link_prev_q <= '0;
    end else begin
      seen_q      <= seen_q | phy_sync_i;
      sync_prev_q <= phy_sync_i;
      nib_prev_q  <= rx_nib_o;
      dv_prev_q   <= rx_dv_o;
      crs_prev_q  <= rx_crs_o;
      col_prev_q  <= rx_col_o;
      link_prev_q <= rx_link_o;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_chg
    assign chg[p] = (rx_nib_o[p*NW +: NW] != nib_prev_q[p*NW +: NW]) ||
                    (rx_dv_o[p] != dv_prev_q[p]) || (rx_crs_o[p] != crs_prev_q[p]) ||
                    (rx_col_o[p] != col_prev_q[p]) || (rx_link_o[p] != link_prev_q[p]);
  end

  AST_MARK_IS_PORT0: assert property (@(posedge clk) disable iff (!rst_n)
    phy_sync_i |-> (phy_txd_o == tx_nib_i[NW-1:0]) && (phy_txen_o == tx_en_i[0])); // R1
  AST_NO_TX_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !phy_sync_i) |-> !phy_txen_o && (phy_txd_o == '0)); // R2
  AST_ONE_PORT_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1); // R4
  AST_ERR_AFTER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |-> sync_prev_q); // R6
  AST_NO_RENEG_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !phy_sync_i) |-> !phy_reneg_o); // R7
  AST_NO_CAPTURE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (chg == '0)); // R9
endmodule

bind tdm_mac_mux tdm_mux_checker #(.NPORTS(NPORTS), .NW(NW)) u_chk (.*);

// File: tb/sim_tdm_mac_mux.sv
module sim_tdm_mac_mux;
  localparam int  NP = 8;
  localparam int  NW = 4;
  localparam time CLK_PERIOD = 50ns;
  localparam int  NCYC = 640;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP*NW-1:0] tx_nib;
  logic [NP-1:0] tx_en, reneg_req;
  logic [NP*NW-1:0] rx_nib;
  logic [NP-1:0] rx_dv, rx_crs, rx_col, rx_link;
  logic sync, rxdv, crs, col, link;
  logic [NW-1:0] rxd, txd;
  logic txen, reneg, serr;

  int checks = 0;
  int errors = 0;

  tdm_mac_mux #(.NPORTS(NP), .NW(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_nib_i(tx_nib), .tx_en_i(tx_en),
    .rx_nib_o(rx_nib), .rx_dv_o(rx_dv), .rx_crs_o(rx_crs), .rx_col_o(rx_col),
    .rx_link_o(rx_link), .reneg_req_i(reneg_req), .phy_sync_i(sync),
    .phy_rxd_i(rxd), .phy_rxdv_i(rxdv), .phy_crs_i(crs), .phy_col_i(col),
    .phy_link_i(link), .phy_txd_o(txd), .phy_txen_o(txen),
    .phy_reneg_o(reneg), .sync_err_o(serr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit   m_lock;
  int   m_cnt;
  bit   m_err;
  int   m_rs [NP];
  logic [NW+3:0] m_rx [NP];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit sync_at(input int c);
    if (c >= 6 && c < 300 && ((c - 6) % 8) == 0) return 1'b1;
    if (c == 305 || c == 306) return 1'b1;           // early then back-to-back
    if (c >= 330 && c < 400 && ((c - 330) % 8) == 0) return 1'b1;
    if (c == 420) return 1'b1;                         // after missing markers
    if (c >= 460 && ((c - 460) % 8) == 0) return 1'b1;
    if (c == 503) return 1'b1;                         // late-in-rotation marker
    return 1'b0;
  endfunction

  bit wd_fired = 1'b0;
  initial begin
    #(CLK_PERIOD * 5000);
    wd_fired = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_nib = '0; tx_en = '0; reneg_req = '0;
    sync = 1'b0; rxd = '0; rxdv = 1'b0; crs = 1'b0; col = 1'b0; link = 1'b0;
    m_lock = 1'b0; m_cnt = 0; m_err = 1'b0;
    for (int p = 0; p < NP; p++) begin m_rs[p] = 0; m_rx[p] = '0; end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(rx_nib == '0, "R9", "rx_nib in reset", int'(rx_nib), 0);
    chk((rx_dv | rx_crs | rx_col | rx_link) == '0, "R9", "rx flags in reset", 1, 0);
    chk(serr == 1'b0, "R9", "sync_err in reset", serr, 0);
    rst_n = 1'b1;

    for (int c = 0; c < NCYC; c++) begin
      bit act;
      int cur;
      int exp_txd, exp_txen, exp_rn;
      @(negedge clk);
      sync = sync_at(c);
      tx_nib = $urandom;
      tx_en = NP'($urandom);
      rxd = NW'($urandom);
      rxdv = $urandom_range(0, 1) == 1;
      crs = $urandom_range(0, 1) == 1;
      col = $urandom_range(0, 3) == 0;
      link = $urandom_range(0, 3) != 0;
      reneg_req = '0;
      if (c == 2) reneg_req[5] = 1'b1;                  // before lock
      if (c == 40) reneg_req[2] = 1'b1;
      if (c >= 50 && c < 62) reneg_req[2] = 1'b1;        // R8: busy requests
      if (c == 120) reneg_req = '1;
      if (c > 200 && ($urandom_range(0, 15) == 0)) reneg_req = NP'($urandom);
      #1;

      act = sync || m_lock;
      cur = sync ? 0 : m_cnt;
      exp_txd  = act ? int'(tx_nib[cur*NW +: NW]) : 0;
      exp_txen = act ? int'(tx_en[cur]) : 0;
      exp_rn   = (act && (m_rs[cur] == 1 || m_rs[cur] == 3)) ? 1 : 0;

      chk(int'(txd) == exp_txd, "R2", "tx nibble (R1 slot order)", int'(txd), exp_txd);
      chk(int'(txen) == exp_txen, "R2", "tx enable (R5 resync)", int'(txen), exp_txen);
      chk(int'(reneg) == exp_rn, "R7", "reneg line (R8 busy ignore)", int'(reneg), exp_rn);
      chk(serr == m_err, "R6", "sync error pulse", serr, m_err);
      for (int p = 0; p < NP; p++) begin
        logic [NW+3:0] got;
        got = {rx_nib[p*NW +: NW], rx_dv[p], rx_crs[p], rx_col[p], rx_link[p]};
        chk(got == m_rx[p], "R3", $sformatf("rx port %0d (R4 hold, R9 unlocked)", p),
            int'(got), int'(m_rx[p]));
      end

      // model update representing the coming rising edge
      m_err = sync && m_lock && (m_cnt != 0);
      if (act) begin
        m_rx[cur] = {rxd, rxdv, crs, col, link};
        m_cnt = (cur + 1) % NP;
      end
      if (sync) m_lock = 1'b1;
      for (int p = 0; p < NP; p++) begin
        if (m_rs[p] == 0) begin
          if (reneg_req[p]) m_rs[p] = 1;
        end else if (act && cur == p) begin
          m_rs[p] = (m_rs[p] + 1) % 4;
        end
      end
    end

    if (!wd_fired) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule